// File: doc/BRIEF.md
# Indexed Network Controller Register File

This block is the 16-bit programmed-I/O register window of a bus-master Ethernet controller. Software reaches it through four fixed byte offsets. One offset is a pointer. Two are data windows that act on the register the pointer selects: one for control registers, one for bus-configuration registers. The last is a reset port, and any read of it returns the whole controller to its idle state.

The main control register (index 0) mixes two kinds of bit. Command bits are turned into one-cycle pulses for the DMA engines. Event flags are sticky: the engines' event pulses set them, and only a write of 1 to a flag's position clears it. A read-only summary bit ORs the flags, and it is gated by the interrupt-enable bit onto the interrupt line. The initialization-done flag is special. It sets only when the engines acknowledge a ring reload that follows an initialization command. Other registers hold the initialization-block address, a saturating missed-frame count and the descriptor-width selector.

Every access completes in the cycle it is presented. There is no back-pressure on the register port. Read data is combinational from the current state and is zero whenever no read is presented.

Top module: `netctl_regfile`

## Requirements
- R1: A write at byte offset 0x12 loads the 7-bit pointer from the low data bits. A read at 0x12 returns the pointer. Reads and writes at 0x10 act on the control register the pointer selects.
- R2: Control registers 1 and 2 hold the low and high halves of the initialization-block address. Both read back, and `ib_addr` = {reg2, reg1}.
- R3: A write to register 0 with bit 0 (init), bit 1 (start) or bit 3 (transmit demand) set raises the matching `cmd_*_p` for exactly the following cycle. Start sets the running state, which reads back as bit 1 = 1 and bit 2 = 0.
- R4: Bit 2 (stop) pulses `cmd_stop_p` and clears the running state (bit 1 = 0, bit 2 = 1). Stop suppresses every other command written in the same word.
- R5: Event pulses set sticky flags in register 0: transmit done at bit 9, receive done at bit 10, memory error at bit 11, missed frame at bit 12, babble at bit 14. Each flag stays set until cleared.
- R6: A register-0 write clears each flag whose bit is 1 and leaves flags whose bit is 0. An event in the same cycle as its clear leaves the flag set.
- R7: Bit 8 (initialization done) sets only on a `reload_done` pulse while an init is pending. An init command makes an init pending. `reload_done` with no init pending is ignored, and stop cancels a pending init.
- R8: Bit 15 reads as the OR of bits 8 through 14. Bit 6 is interrupt enable and is reloaded by every register-0 write. `irq` = summary AND enable.
- R9: Each `ev_missed` pulse increments the count that register 112 returns. The count saturates at 0xFFFF.
- R10: With the pointer at 20, a write at 0x16 loads bit 1 into `desc32_mode`, and a read at 0x16 returns it in bit 1. For any other pointer value, writes at 0x16 are ignored and reads return 0.
- R11: A read at 0x14 returns 0. On that edge the pointer, flags, enable, running state, pending init, address, count and mode are all cleared, and `ctl_rst_p` pulses in the next cycle.
- R12: After reset, register 0 reads 0x0004 and every other register and output is 0.
- R13: Accesses with `bus_sel` low, and writes to unmapped offsets or indices (including read-only index 112), change nothing. Reads of those return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_off | input | 5 | Byte offset from base |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| ev_tx_done | input | 1 | Transmit-done event pulse |
| ev_rx_done | input | 1 | Receive-done event pulse |
| ev_mem_err | input | 1 | Bus-master memory error pulse |
| ev_missed | input | 1 | Missed-frame event pulse |
| ev_babble | input | 1 | Babble event pulse |
| reload_done | input | 1 | Ring-reload acknowledge from the engines |
| cmd_init_p | output | 1 | Initialization command pulse |
| cmd_start_p | output | 1 | Start command pulse |
| cmd_stop_p | output | 1 | Stop command pulse |
| cmd_tdmd_p | output | 1 | Transmit-demand pulse |
| ctl_rst_p | output | 1 | Controller reset pulse after a reset-port read |
| irq | output | 1 | Interrupt request |
| ib_addr | output | 32 | Initialization-block address |
| desc32_mode | output | 1 | 32-bit descriptor style selected |

## Verification
The bench goes after the collisions inside the main register.

- **Stop written with start or init.** A design that let either pulse through would restart engines that software meant to halt.
- **A flag's clear landing on the same edge as its event.** A design that favoured the clear would silently drop an event.
- **An acknowledge-only write with the commands masked off.** Because enable is reloaded by every write, a design that treated enable as sticky would keep interrupting after software disabled it.
- **The initialization-done handshake.** A stray `reload_done`, or one after a stop, must not set the flag; a design that got this wrong would report a reload that never happened.
- **Counter saturation.** A counter that wraps would report zero missed frames after heavy loss.
- **The reset-port read.** The edge where it clears everything is checked against events and writes that arrive around it.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  // Byte offsets of the four access ports
  localparam int OFF_RDP = 'h10;  // control data window
  localparam int OFF_RAP = 'h12;  // pointer
  localparam int OFF_RST = 'h14;  // reset on read
  localparam int OFF_BDP = 'h16;  // bus-configuration data window

  // Register indices
  localparam int REG_CTL  = 0;
  localparam int REG_IBLO = 1;
  localparam int REG_IBHI = 2;
  localparam int REG_MISS = 112;
  localparam int BREG_SW  = 20;

  // Bit positions in the main register
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_IE   = 6;
  localparam int B_SUM  = 15;
  localparam int B_DESC = 1;      // in bus-configuration register 20

  // Sticky flags: index 0 is initialization done, 1..5 come from engines
  localparam int N_EV = 6;
  localparam int EV_POS [N_EV] = '{8, 9, 10, 11, 12, 14};

  typedef enum logic [2:0] {
    PORT_NONE, PORT_RDP, PORT_RAP, PORT_RST, PORT_BDP
  } port_e;
endpackage

// File: rtl/netctl_bus_decode.sv
module netctl_bus_decode
  import netctl_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_off,
  output port_e         port,
  output logic          wr_rap,
  output logic          wr_rdp,
  output logic          wr_bdp,
  output logic          rd_rst,
  output logic          rd_any
);
  always_comb begin
    port = PORT_NONE;
    if (bus_sel) begin
      case (bus_off)
        AW'(OFF_RDP): port = PORT_RDP;
        AW'(OFF_RAP): port = PORT_RAP;
        AW'(OFF_RST): port = PORT_RST;
        AW'(OFF_BDP): port = PORT_BDP;
        default:      port = PORT_NONE;
      endcase
    end
  end

  assign wr_rap = bus_wr && (port == PORT_RAP);
  assign wr_rdp = bus_wr && (port == PORT_RDP);
  assign wr_bdp = bus_wr && (port == PORT_BDP);
  assign rd_rst = bus_rd && (port == PORT_RST);
  assign rd_any = bus_rd && (port != PORT_NONE);
endmodule

// File: rtl/netctl_csr0.sv
module netctl_csr0
  import netctl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic [N_EV-2:0] ev_ext,
  input  logic            reload_done,
  output logic [DW-1:0]   image,
  output logic [N_EV-1:0] flags,
  output logic            ie,
  output logic            run,
  output logic            cmd_init_p,
  output logic            cmd_start_p,
  output logic            cmd_stop_p,
  output logic            cmd_tdmd_p,
  output logic            irq
);
  logic stop_w, init_w, start_w, tdmd_w, pend, idon_set;
  logic [N_EV-1:0] set_vec;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  // Stop overrides every other command in the same word
  assign stop_w   = wr && wdata[B_STOP];
  assign init_w   = wr && wdata[B_INIT] && !stop_w;
  assign start_w  = wr && wdata[B_STRT] && !stop_w;
  assign tdmd_w   = wr && wdata[B_TDMD] && !stop_w;
  assign idon_set = reload_done && pend && !stop_w;
  assign set_vec  = {ev_ext, idon_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cmd_init_p, cmd_start_p, cmd_stop_p, cmd_tdmd_p} <= '0;
      pend <= 1'b0;
      run  <= 1'b0;
      ie   <= 1'b0;
    end else if (soft_clr) begin
      {cmd_init_p, cmd_start_p, cmd_stop_p, cmd_tdmd_p} <= '0;
      pend <= 1'b0;
      run  <= 1'b0;
      ie   <= 1'b0;
    end else begin
      cmd_init_p  <= init_w;
      cmd_start_p <= start_w;
      cmd_stop_p  <= stop_w;
      cmd_tdmd_p  <= tdmd_w;
      if (stop_w)           pend <= 1'b0;
      else if (init_w)      pend <= 1'b1;
      else if (reload_done) pend <= 1'b0;
      if (stop_w)       run <= 1'b0;
      else if (start_w) run <= 1'b1;
      if (wr) ie <= wdata[B_IE];
    end
  end

  // One sticky flag per event; a set in the same cycle beats a clear
  for (genvar g = 0; g < N_EV; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flags[g] <= 1'b0;
      else if (soft_clr)                 flags[g] <= 1'b0;
      else if (set_vec[g])               flags[g] <= 1'b1;
      else if (wr && wdata[EV_POS[g]])   flags[g] <= 1'b0;
    end
  end

  always_comb begin
    image = '0;
    for (int i = 0; i < N_EV; i++) image[EV_POS[i]] = flags[i];
    image[B_SUM]  = |flags;
    image[B_IE]   = ie;
    image[B_STRT] = run;
    image[B_STOP] = !run;
  end

  assign irq = (|flags) && ie;
endmodule

// File: rtl/netctl_sat_cnt.sv
module netctl_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q <= '0;
    else if (clr)                q <= '0;
    else if (inc && (q != TOP))  q <= q + 1'b1;
  end
endmodule

// File: rtl/netctl_regfile.sv
module netctl_regfile
  import netctl_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DW    = 16,
  parameter int PTR_W = 7,
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_off,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ev_tx_done,
  input  logic            ev_rx_done,
  input  logic            ev_mem_err,
  input  logic            ev_missed,
  input  logic            ev_babble,
  input  logic            reload_done,
  output logic            cmd_init_p,
  output logic            cmd_start_p,
  output logic            cmd_stop_p,
  output logic            cmd_tdmd_p,
  output logic            ctl_rst_p,
  output logic            irq,
  output logic [2*DW-1:0] ib_addr,
  output logic            desc32_mode
);
  localparam logic [PTR_W-1:0] P_CTL  = PTR_W'(REG_CTL);
  localparam logic [PTR_W-1:0] P_IBLO = PTR_W'(REG_IBLO);
  localparam logic [PTR_W-1:0] P_IBHI = PTR_W'(REG_IBHI);
  localparam logic [PTR_W-1:0] P_MISS = PTR_W'(REG_MISS);
  localparam logic [PTR_W-1:0] P_SW   = PTR_W'(BREG_SW);

  port_e             port;
  logic              wr_rap, wr_rdp, wr_bdp, rd_rst, rd_any, soft_clr;
  logic [PTR_W-1:0]  ptr;
  logic [DW-1:0]     ib_lo, ib_hi, csr_image;
  logic [N_EV-1:0]   ev_flags;
  logic              csr_ie, csr_run;
  logic [CNT_W-1:0]  miss_cnt;

  netctl_bus_decode #(.AW(AW)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_off(bus_off),
    .port(port), .wr_rap(wr_rap), .wr_rdp(wr_rdp), .wr_bdp(wr_bdp),
    .rd_rst(rd_rst), .rd_any(rd_any)
  );

  assign soft_clr = rd_rst;

  netctl_csr0 #(.DW(DW)) u_csr0 (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .wr(wr_rdp && (ptr == P_CTL)), .wdata(bus_wdata),
    .ev_ext({ev_babble, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done}),
    .reload_done(reload_done), .image(csr_image), .flags(ev_flags),
    .ie(csr_ie), .run(csr_run),
    .cmd_init_p(cmd_init_p), .cmd_start_p(cmd_start_p),
    .cmd_stop_p(cmd_stop_p), .cmd_tdmd_p(cmd_tdmd_p), .irq(irq)
  );

  netctl_sat_cnt #(.W(CNT_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .inc(ev_missed), .q(miss_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; ib_lo <= '0; ib_hi <= '0; desc32_mode <= 1'b0; ctl_rst_p <= 1'b0;
    end else begin
      ctl_rst_p <= soft_clr;
      if (soft_clr) begin
        ptr <= '0; ib_lo <= '0; ib_hi <= '0; desc32_mode <= 1'b0;
      end else begin
        if (wr_rap) ptr <= bus_wdata[PTR_W-1:0];
        if (wr_rdp && ptr == P_IBLO) ib_lo <= bus_wdata;
        if (wr_rdp && ptr == P_IBHI) ib_hi <= bus_wdata;
        if (wr_bdp && ptr == P_SW)   desc32_mode <= bus_wdata[B_DESC];
      end
    end
  end

  assign ib_addr = {ib_hi, ib_lo};

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (port)
        PORT_RAP: bus_rdata = DW'(ptr);
        PORT_RDP: begin
          case (ptr)
            P_CTL:   bus_rdata = csr_image;
            P_IBLO:  bus_rdata = ib_lo;
            P_IBHI:  bus_rdata = ib_hi;
            P_MISS:  bus_rdata = DW'(miss_cnt);
            default: bus_rdata = '0;
          endcase
        end
        PORT_BDP: if (ptr == P_SW) bus_rdata[B_DESC] = desc32_mode;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/netctl_regfile_chk.sv
module netctl_regfile_chk #(
  parameter int N_EV  = 6,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic             cmd_init_p,
  input logic             cmd_start_p,
  input logic             cmd_stop_p,
  input logic             cmd_tdmd_p,
  input logic             ctl_rst_p,
  input logic             irq,
  input logic             ie,
  input logic             run,
  input logic [N_EV-1:0]  ev_flags,
  input logic             reload_done,
  input logic [CNT_W-1:0] miss_cnt
);
  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop_p |-> !(cmd_start_p || cmd_init_p || cmd_tdmd_p));

  assert_stop_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop_p |-> !run);

  assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start_p |-> run);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);

  assert_idon_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_flags[0]) |-> $past(reload_done));

  assert_miss_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt == {CNT_W{1'b1}} && !soft_clr) |=> miss_cnt == {CNT_W{1'b1}});

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (ctl_rst_p && !run && !ie && ev_flags == '0 && miss_cnt == '0));
endmodule

bind netctl_regfile netctl_regfile_chk #(.N_EV(netctl_pkg::N_EV), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
  .cmd_init_p(cmd_init_p), .cmd_start_p(cmd_start_p),
  .cmd_stop_p(cmd_stop_p), .cmd_tdmd_p(cmd_tdmd_p),
  .ctl_rst_p(ctl_rst_p), .irq(irq), .ie(csr_ie), .run(csr_run),
  .ev_flags(ev_flags), .reload_done(reload_done), .miss_cnt(miss_cnt)
);

// File: tb/netctl_regfile_test.sv
`timescale 1ns/1ps
module netctl_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        sel = 0, wr = 0, rd = 0;
  logic [4:0]  off = 0;
  logic [15:0] wd = 0;
  logic [4:0]  ev = 0;   // {babble, missed, mem, rx, tx}
  logic        reload = 0;

  logic [15:0] rdata;
  logic        c_init, c_start, c_stop, c_tdmd, c_rst, irq, desc;
  logic [31:0] ib;

  netctl_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
    .bus_off(off), .bus_wdata(wd), .bus_rdata(rdata),
    .ev_tx_done(ev[0]), .ev_rx_done(ev[1]), .ev_mem_err(ev[2]),
    .ev_missed(ev[3]), .ev_babble(ev[4]), .reload_done(reload),
    .cmd_init_p(c_init), .cmd_start_p(c_start), .cmd_stop_p(c_stop),
    .cmd_tdmd_p(c_tdmd), .ctl_rst_p(c_rst), .irq(irq),
    .ib_addr(ib), .desc32_mode(desc)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit armed = 0, done = 0;

  // Behavioural reference model
  int          m_ptr, m_miss;
  logic [15:0] m_fl, m_lo, m_hi;
  bit          m_ie, m_run, m_pend, m_desc;
  bit          m_pi, m_ps, m_pt, m_pd, m_pr;

  task automatic model_reset();
    m_ptr = 0; m_miss = 0; m_fl = 0; m_lo = 0; m_hi = 0;
    m_ie = 0; m_run = 0; m_pend = 0; m_desc = 0;
    m_pi = 0; m_ps = 0; m_pt = 0; m_pd = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset(); m_pr = 0;
    end else if (sel && rd && off == 5'h14) begin
      model_reset(); m_pr = 1;
    end else begin
      bit cw, st, in_, sa, td, idset;
      logic [15:0] setv, clrv;
      m_pr = 0;
      cw  = sel && wr && off == 5'h10 && m_ptr == 0;
      st  = cw && wd[2];
      in_ = cw && wd[0] && !st;
      sa  = cw && wd[1] && !st;
      td  = cw && wd[3] && !st;
      idset = reload && m_pend && !st;
      setv = 16'(idset) << 8 | 16'(ev[0]) << 9 | 16'(ev[1]) << 10 |
             16'(ev[2]) << 11 | 16'(ev[3]) << 12 | 16'(ev[4]) << 14;
      clrv = cw ? (wd & 16'h5F00) : 16'h0;
      m_fl = (m_fl & ~clrv) | setv;
      if (st) m_pend = 0; else if (in_) m_pend = 1; else if (reload) m_pend = 0;
      if (st) m_run = 0; else if (sa) m_run = 1;
      if (cw) m_ie = wd[6];
      m_pi = in_; m_ps = sa; m_pt = st; m_pd = td;
      if (ev[3] && m_miss < 65535) m_miss++;
      if (sel && wr && off == 5'h10 && m_ptr == 1) m_lo = wd;
      if (sel && wr && off == 5'h10 && m_ptr == 2) m_hi = wd;
      if (sel && wr && off == 5'h16 && m_ptr == 20) m_desc = wd[1];
      if (sel && wr && off == 5'h12) m_ptr = int'(wd[6:0]);
    end
  end

  function automatic logic [15:0] m_image();
    logic [15:0] v = m_fl;
    if (m_fl != 0) v[15] = 1;
    v[6] = m_ie; v[1] = m_run; v[2] = !m_run;
    return v;
  endfunction

  function automatic logic [15:0] exp_rd(output string tag);
    tag = "R13";
    if (!(sel && rd)) return 16'h0;
    case (off)
      5'h12: begin tag = "R1"; return 16'(m_ptr); end
      5'h14: begin tag = "R11"; return 16'h0; end
      5'h16: begin tag = "R10"; return (m_ptr == 20) ? {14'h0, m_desc, 1'b0} : 16'h0; end
      5'h10: case (m_ptr)
        0:   begin tag = "R3 R5 R6 R7 R8"; return m_image(); end
        1:   begin tag = "R2"; return m_lo; end
        2:   begin tag = "R2"; return m_hi; end
        112: begin tag = "R9"; return 16'(m_miss); end
        default: return 16'h0;
      endcase
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && armed && !done) begin
      string t;
      logic [15:0] e;
      e = exp_rd(t);
      chk({t, " rdata"}, 32'(rdata), 32'(e));
      chk("R3 init pulse", 32'(c_init), 32'(m_pi));
      chk("R3 start pulse", 32'(c_start), 32'(m_ps));
      chk("R4 stop pulse", 32'(c_stop), 32'(m_pt));
      chk("R3 tdmd pulse", 32'(c_tdmd), 32'(m_pd));
      chk("R11 reset pulse", 32'(c_rst), 32'(m_pr));
      chk("R8 irq", 32'(irq), 32'(m_fl != 0 && m_ie));
      chk("R2 ib_addr", ib, {m_hi, m_lo});
      chk("R10 desc32", 32'(desc), 32'(m_desc));
    end
  end

  task automatic cyc(bit s, bit w, bit r, logic [4:0] o, logic [15:0] d,
                     logic [4:0] e = 0, bit rl = 0);
    @(posedge clk); #1;
    sel = s; wr = w; rd = r; off = o; wd = d; ev = e; reload = rl;
  endtask
  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask
  task automatic wreg(logic [4:0] o, logic [15:0] d); cyc(1, 1, 0, o, d); endtask
  task automatic rchk(logic [4:0] o, logic [15:0] exp, string tag);
    cyc(1, 0, 1, o, 0);
    @(negedge clk);
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired: actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; armed = 1;
    // R12: reset state
    rchk(5'h10, 16'h0004, "R12 reset image");
    rchk(5'h12, 16'h0000, "R12 reset pointer");
    // R1 R2: pointer and address halves
    wreg(5'h12, 1); wreg(5'h10, 16'h1234);
    wreg(5'h12, 2); wreg(5'h10, 16'hABCD);
    rchk(5'h10, 16'hABCD, "R2 high half");
    rchk(5'h12, 16'h0002, "R1 pointer readback");
    // R3 R7 R8: init with enable, then reload acknowledge
    wreg(5'h12, 0); wreg(5'h10, 16'h0041); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 1); idle(1);
    rchk(5'h10, 16'h8144, "R7 idon after reload");
    cyc(0, 0, 0, 0, 0, 0, 1); idle(1);            // R7 stray reload
    wreg(5'h10, 16'h0100); idle(1);
    rchk(5'h10, 16'h0004, "R7 idon cleared, stray reload ignored");
    // R3 R4: start, demand, stop with start and init
    wreg(5'h10, 16'h0042); wreg(5'h10, 16'h0048); idle(1);
    wreg(5'h10, 16'h0047); idle(1);
    rchk(5'h10, 16'h0044, "R4 stop wins");
    // R7: stop cancels a pending init
    wreg(5'h10, 16'h0001); wreg(5'h10, 16'h0004);
    cyc(0, 0, 0, 0, 0, 0, 1); idle(1);
    rchk(5'h10, 16'h0004, "R7 stop cancels pending init");
    // R5 R6: events, partial clear, set-beats-clear
    cyc(0, 0, 0, 0, 0, 5'b10111); idle(1);
    rchk(5'h10, 16'hCE04, "R5 flags set");
    wreg(5'h10, 16'h0200);
    cyc(1, 1, 0, 5'h10, 16'h0400, 5'b00010);
    rchk(5'h10, 16'hCC04, "R6 set beats clear");
    // R8: masked acknowledge reloads enable to 0
    wreg(5'h10, 16'h0000); idle(1);
    @(negedge clk); chk("R8 irq low after enable cleared", 32'(irq), 32'h0);
    wreg(5'h10, 16'h5F40); idle(1);
    // R10 R13: bus configuration and unmapped accesses
    wreg(5'h12, 20); wreg(5'h16, 16'h0002);
    rchk(5'h16, 16'h0002, "R10 desc readback");
    wreg(5'h12, 21); wreg(5'h16, 16'h0000);
    rchk(5'h16, 16'h0000, "R10 other index reads 0");
    wreg(5'h12, 5); wreg(5'h10, 16'hFFFF);
    rchk(5'h10, 16'h0000, "R13 unmapped index");
    cyc(0, 1, 0, 5'h12, 16'h0001);
    rchk(5'h12, 16'h0005, "R13 unselected write ignored");
    rchk(5'h18, 16'h0000, "R13 unmapped offset");
    // R9: saturation
    wreg(5'h12, 112); wreg(5'h10, 16'h0000);
    for (int i = 0; i < 65540; i++) cyc(0, 0, 0, 0, 0, 5'b01000);
    idle(1);
    rchk(5'h10, 16'hFFFF, "R9 saturated count");
    // R11: reset read
    cyc(1, 0, 1, 5'h14, 0, 5'b11111); idle(1);
    wreg(5'h12, 0);
    rchk(5'h10, 16'h0004, "R11 image after reset read");
    // Mixed traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int o = $urandom % 16;
      logic [4:0] of;
      logic [15:0] d;
      int pc = $urandom % 6;
      of = o < 6 ? 5'h10 : o < 10 ? 5'h12 : o < 14 ? 5'h16 : (o == 14 && ($urandom % 8 == 0)) ? 5'h14 : 5'h18;
      d = 16'($urandom);
      if (of == 5'h12) d = 16'(pc == 0 ? 0 : pc == 1 ? 1 : pc == 2 ? 2 : pc == 3 ? 20 : pc == 4 ? 112 : 7);
      cyc($urandom % 4 != 0, $urandom % 2 == 0, $urandom % 2 == 0, of, d,
          5'($urandom) & 5'($urandom), $urandom % 6 == 0);
    end
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule